// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between an on-chip request port and an external asynchronous static RAM of 128K bytes. Each accepted request is one byte read or one byte write. The controller turns it into a cycle on the memory's chip-select, write-strobe and output-enable lines, plus a split data bus. The split bus has an outgoing byte, a drive-enable and an incoming byte, and the pad ring joins them into one bidirectional bus.

All memory timing is counted in whole clock cycles. The controller takes the clock period and the memory's nanosecond limits as parameters and rounds each window up to an integer cycle count:

- read access time;
- strobe pulse width together with the data-before-strobe-end time;
- output release time.

A write is closed by the rising edge of the write strobe. The address and write data stay unchanged for the whole time the strobe is low. The controller never drives the bus while the memory may still be driving it. Between requests the chip select is released, so the memory rests in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it, chip select, write strobe and output enable are all high (inactive), the bus drive-enable is low, `rsp_valid` is low and `req_ready` is high.
- R2: A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops on the cycle after acceptance. A request presented while `req_ready` is low is not acted on: it makes no memory cycle and changes no stored byte.
- R3: A read holds chip select and output enable low, with the write strobe high, for RD_CYC = ceil(T_ACC_NS / CLK_PERIOD_NS) cycles, with a minimum of 1. The byte on `mem_dq_i` is captured at the clock edge that ends this window.
- R4: The captured read byte appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the cycle after the read window. `req_ready` returns high on the following cycle, so a read keeps `req_ready` low for RD_CYC + 1 cycles.
- R5: A write has three phases:
  - one setup cycle with chip select low, the strobe high and the data driven;
  - WP_CYC = ceil(max(T_WP_NS, T_DW_NS) / CLK_PERIOD_NS) cycles with the strobe low;
  - one recovery cycle with the strobe high while chip select, address and data are held.

  The memory captures the byte on the strobe's rising edge.
- R6: Address and outgoing data do not change while the write strobe stays low.
- R7: The bus drive-enable is never high while output enable is low, and it is low on the cycle that follows any cycle with output enable low.
- R8: A write accepted directly after a read first spends TURN_CYC = ceil(T_HZ_NS / CLK_PERIOD_NS) cycles, with a minimum of 1, with all memory controls high and the bus released. That write keeps `req_ready` low for TURN_CYC + WP_CYC + 2 cycles, while any other write keeps it low for WP_CYC + 2 cycles.
- R9: Whenever `req_ready` is high, chip select is high and the bus is released.
- R10: The write strobe is low only while chip select is low, output enable is high and the bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Byte address |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | One-cycle pulse, read byte valid |
| rsp_rdata | output | DATA_W (8) | Read byte |
| mem_addr | output | ADDR_W (17) | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DATA_W (8) | Byte to drive on the memory bus |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W (8) | Byte sampled from the memory bus |

## Verification
The bench parameterises the controller for a slow memory, so every window spans several clocks. Its memory model returns a junk byte until the access time has elapsed. A controller that captures one cycle early therefore reads junk, and one that shortens the strobe or drops the setup or recovery cycle shows a wrong busy length or strobe-low count. Writes that immediately follow a read must show the extra turnaround cycles; a design without them finishes the write too soon. A request pushed in while the controller is busy must leave no trace, which the bench confirms by reading the location back. The model also flags address or data movement under a low strobe, and any overlap between the controller driving and the memory driving.

// File: rtl/sram_async_ctrl_pkg.sv
package sram_async_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_ACCESS  = 3'd1,
        ST_RD_DONE    = 3'd2,
        ST_WR_SETUP   = 3'd3,
        ST_WR_PULSE   = 3'd4,
        ST_WR_RECOVER = 3'd5,
        ST_TURN       = 3'd6
    } ctrl_state_e;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int lim_ns, input int period_ns);
        int c;
        c = (lim_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_async_ctrl_timer.sv
module sram_async_ctrl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = (cnt_q == '0);

    always_comb begin
        if (load)      cnt_d = load_val;
        else if (done) cnt_d = cnt_q;
        else           cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sram_async_ctrl_rdcap.sv
module sram_async_ctrl_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              vld
);
    logic [DATA_W-1:0] byte_d, byte_q;
    logic              vld_d, vld_q;

    always_comb begin
        byte_d = stb ? din : byte_q;
        vld_d  = stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            byte_q <= byte_d;
            vld_q  <= vld_d;
        end
    end

    assign dout = byte_q;
    assign vld  = vld_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_async_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_ACC_NS      = 10,
    parameter int T_WP_NS       = 7,
    parameter int T_DW_NS       = 5,
    parameter int T_HZ_NS       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RD_CYC   = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
    localparam int WP_CYC   = ns_to_cyc(max2(T_WP_NS, T_DW_NS), CLK_PERIOD_NS);
    localparam int TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC  = max2(RD_CYC, max2(WP_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_CYC - 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              last_rd;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cap_stb;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_stb  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.ce_n  = 1'b1;
                r_d.we_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.dq_oe = 1'b0;
                if (req_valid) begin
                    r_d.addr = req_addr;
                    if (req_write) begin
                        r_d.wdata   = req_wdata;
                        r_d.last_rd = 1'b0;
                        if (r_q.last_rd) begin
                            r_d.st   = ST_TURN;
                            tmr_load = 1'b1;
                            tmr_val  = TURN_LOAD;
                        end else begin
                            r_d.st    = ST_WR_SETUP;
                            r_d.ce_n  = 1'b0;
                            r_d.dq_oe = 1'b1;
                        end
                    end else begin
                        r_d.st      = ST_RD_ACCESS;
                        r_d.ce_n    = 1'b0;
                        r_d.oe_n    = 1'b0;
                        r_d.last_rd = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = RD_LOAD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done) begin
                    cap_stb  = 1'b1;
                    r_d.st   = ST_RD_DONE;
                    r_d.ce_n = 1'b1;
                    r_d.oe_n = 1'b1;
                end
            end
            ST_RD_DONE: r_d.st = ST_IDLE;
            ST_TURN: begin
                if (tmr_done) begin
                    r_d.st    = ST_WR_SETUP;
                    r_d.ce_n  = 1'b0;
                    r_d.dq_oe = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                r_d.st   = ST_WR_PULSE;
                r_d.we_n = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = WP_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    r_d.st   = ST_WR_RECOVER;
                    r_d.we_n = 1'b1;
                end
            end
            ST_WR_RECOVER: begin
                r_d.st    = ST_IDLE;
                r_d.ce_n  = 1'b1;
                r_d.dq_oe = 1'b0;
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.ce_n  = 1'b1;
                r_d.we_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.addr    <= '0;
            r_q.wdata   <= '0;
            r_q.ce_n    <= 1'b1;
            r_q.we_n    <= 1'b1;
            r_q.oe_n    <= 1'b1;
            r_q.dq_oe   <= 1'b0;
            r_q.last_rd <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    sram_async_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_async_ctrl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (cap_stb),
        .din   (mem_dq_i),
        .dout  (rsp_rdata),
        .vld   (rsp_valid)
    );

    assign req_ready = (r_q.st == ST_IDLE);
    assign mem_addr  = r_q.addr;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.dq_oe;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    // R1: controls settle to idle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid));

    // R2: ready drops after an accepted request
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: output enable only with chip select low and strobe high
    p_read_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    // R3: a response only follows a read window
    p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    // R4: single-cycle response, ready next
    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R5: write ends with chip select and data still held
    p_wr_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));

    // R6: address and data frozen under a low strobe
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> (mem_we_n || ($stable(mem_addr) && $stable(mem_dq_o))));

    // R7: never drive against the memory
    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R7: bus stays released right after a read window
    p_release_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> !mem_dq_oe);

    // R9: idle means standby
    p_idle_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_dq_oe));

    // R10: strobe qualified by chip select, output enable high and drive on
    p_strobe_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
    localparam int AW     = 17;
    localparam int DW     = 8;
    localparam int CLK_NS = 20;
    // Slow memory so every window spans several clocks
    localparam int ACC_NS = 50;
    localparam int WP_NS  = 30;
    localparam int DW_NS  = 25;
    localparam int HZ_NS  = 25;
    localparam int E_RD   = (ACC_NS + CLK_NS - 1) / CLK_NS;                               // 3
    localparam int E_WP   = (((WP_NS > DW_NS) ? WP_NS : DW_NS) + CLK_NS - 1) / CLK_NS;    // 2
    localparam int E_TURN = (HZ_NS + CLK_NS - 1) / CLK_NS;                                // 2

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK_NS), .T_ACC_NS(ACC_NS),
        .T_WP_NS(WP_NS), .T_DW_NS(DW_NS), .T_HZ_NS(HZ_NS)
    ) u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [DW-1:0] model_mem [int];
    logic [DW-1:0] ref_mem   [int];

    function automatic logic [DW-1:0] rd_model(input int a);
        return model_mem.exists(a) ? model_mem[a] : '0;
    endfunction
    function automatic logic [DW-1:0] rd_ref(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : '0;
    endfunction

    logic          rd_mode;
    logic          prev_rd_mode = 1'b0;
    logic          prev_we_low  = 1'b0;
    logic [AW-1:0] prev_addr    = '0;
    logic [DW-1:0] prev_dq      = '0;
    logic [DW-1:0] model_dq     = 8'hEE;
    int            acc_cnt      = 0;
    int            rel_cnt      = 100;
    int            we_low_cnt   = 0;
    int            viol_r6 = 0, viol_r7 = 0, viol_r8 = 0, viol_r10 = 0, viol_r5 = 0;

    assign rd_mode  = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_i = rd_mode ? model_dq : 8'hFF;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_mode) begin
                if (prev_rd_mode && mem_addr == prev_addr) acc_cnt = acc_cnt + 1;
                else                                       acc_cnt = 0;
                // junk until the access time has passed by the next rising edge
                model_dq = ((acc_cnt + 1) * CLK_NS >= ACC_NS) ? rd_model(int'(mem_addr)) : 8'hEE;
                rel_cnt  = 0;
            end else begin
                rel_cnt = rel_cnt + 1;
            end
            if (mem_dq_oe && rd_mode) viol_r7++;
            if (mem_dq_oe && !rd_mode && rel_cnt * CLK_NS < HZ_NS) viol_r8++;
            if (!mem_we_n && (mem_ce_n || !mem_oe_n || !mem_dq_oe)) viol_r10++;
            if (prev_we_low && !mem_we_n && (mem_addr != prev_addr || mem_dq_o != prev_dq)) viol_r6++;
            if (!mem_we_n) we_low_cnt = we_low_cnt + 1;
        end
        prev_rd_mode = rd_mode;
        prev_we_low  = !mem_we_n;
        prev_addr    = mem_addr;
        prev_dq      = mem_dq_o;
    end

    // write captured on the rising edge of the strobe
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) begin
            if (!mem_dq_oe || we_low_cnt * CLK_NS < ((WP_NS > DW_NS) ? WP_NS : DW_NS)) viol_r5++;
            model_mem[int'(mem_addr)] = mem_dq_o;
        end
        we_low_cnt = 0;
    end

    // ---------------- stimulus ----------------
    localparam int NVEC = 13;
    // {write, address, data}
    localparam logic [AW+DW:0] VEC [NVEC] = '{
        {1'b1, 17'h00000, 8'hA5},
        {1'b1, 17'h1FFFF, 8'h3C},
        {1'b0, 17'h00000, 8'h00},
        {1'b0, 17'h1FFFF, 8'h00},
        {1'b1, 17'h0ABCD, 8'h5A},
        {1'b1, 17'h0ABCE, 8'hC3},
        {1'b0, 17'h0ABCD, 8'h00},
        {1'b0, 17'h0ABCE, 8'h00},
        {1'b1, 17'h0ABCD, 8'h00},
        {1'b0, 17'h0ABCD, 8'h00},
        {1'b0, 17'h12345, 8'h00},
        {1'b1, 17'h12345, 8'hFF},
        {1'b0, 17'h12345, 8'h00}
    };

    bit prev_was_rd = 1'b0;

    task automatic run_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit inj, input logic [AW-1:0] inj_a, input logic [DW-1:0] inj_d);
        int busy = 0, ce_lo = 0, we_lo = 0, oe_lo = 0, rv = 0, idle_ce = 0, exp_busy;
        logic [DW-1:0] rd = '0;
        logic [DW-1:0] exp_rd;
        exp_rd   = rd_ref(int'(a));
        exp_busy = wr ? ((prev_was_rd ? E_TURN : 0) + E_WP + 2) : (E_RD + 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (inj) begin
            req_write = !wr; req_addr = inj_a; req_wdata = inj_d;
        end else begin
            req_valid = 1'b0;
        end
        while (!req_ready && busy < 200) begin
            busy++;
            if (!mem_ce_n) ce_lo++;
            if (!mem_we_n) we_lo++;
            if (!mem_oe_n) oe_lo++;
            if (rsp_valid) begin rv++; rd = rsp_rdata; end
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (wr) begin
            check(busy == exp_busy, prev_was_rd ? "R8 busy after read" : "R5 busy", busy, exp_busy);
            check(we_lo == E_WP, "R5 strobe low cycles", we_lo, E_WP);
            check(ce_lo == E_WP + 2, "R5 select low cycles", ce_lo, E_WP + 2);
            ref_mem[int'(a)] = d;
        end else begin
            check(busy == exp_busy, "R4 read busy", busy, exp_busy);
            check(oe_lo == E_RD, "R3 enable low cycles", oe_lo, E_RD);
            check(rv == 1, "R4 valid pulses", rv, 1);
            check(rd == exp_rd, "R3 read data", rd, exp_rd);
        end
        check(mem_ce_n && !mem_dq_oe, "R9 standby on ready", {mem_ce_n, mem_dq_oe}, 2'b10);
        for (int k = 0; k < 3; k++) begin
            if (!mem_ce_n || !req_ready) idle_ce++;
            @(negedge clk);
        end
        check(idle_ce == 0, inj ? "R2 ignored request" : "R9 idle standby", idle_ce, 0);
        prev_was_rd = !wr;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mem_ce_n && mem_we_n && mem_oe_n, "R1 controls high in reset",
              {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        check(!mem_dq_oe && !rsp_valid && req_ready, "R1 bus, valid, ready in reset",
              {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, "R1 after release",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);

        for (int i = 0; i < NVEC; i++) begin
            run_op(VEC[i][AW+DW], VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], 1'b0, '0, '0);
        end

        // R2: read pushed in during a write is not acted on
        run_op(1'b1, 17'h0F0F0, 8'h99, 1'b1, 17'h1FFFF, 8'h00);
        // R2: write pushed in during a read must not change the byte
        run_op(1'b0, 17'h0F0F0, 8'h00, 1'b1, 17'h0F0F0, 8'h11);
        run_op(1'b0, 17'h0F0F0, 8'h00, 1'b0, '0, '0);
        check(rd_model(32'h0F0F0) == 8'h99, "R2 stored byte unchanged", rd_model(32'h0F0F0), 8'h99);

        // R8 again: write right after read of a different location
        run_op(1'b1, 17'h00001, 8'h7E, 1'b0, '0, '0);
        run_op(1'b0, 17'h00001, 8'h00, 1'b0, '0, '0);

        check(viol_r5 == 0, "R5 strobe width or drive at capture", viol_r5, 0);
        check(viol_r6 == 0, "R6 address or data moved under strobe", viol_r6, 0);
        check(viol_r7 == 0, "R7 bus contention", viol_r7, 0);
        check(viol_r8 == 0, "R8 drive before memory release", viol_r8, 0);
        check(viol_r10 == 0, "R10 strobe qualification", viol_r10, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule